// File: doc/BRIEF.md
# Crank-Slaved Cam Signal Generator

This block drives up to four cam sensor lines whose edges are tied to an incoming crank angle. Each cam owns a table of edge angles, in angle units where one crank revolution spans `DEG360` counts. The output level of a cam is set by how many of its table entries lie at or below its effective angle. Each time the effective angle passes an entry, the line flips.

Before the engine runs, the tables are filled from a word stream. Words go to the configured cams in round-robin order. All outputs stay low until the last expected word has arrived. A per-cam timing offset can be changed while running, which shifts the profile for variable valve timing. In half-speed mode the cam turns once for every two crank revolutions. A revolution marker from the crank then selects which half of a 0 to 720 degree cycle is current. The block exports this adjusted angle for other crank-related logic.

Top module: `cam_gen_top`

## Requirements
- R1: Load word k (counting from 0, with N cams configured) is stored in cam k mod N at table slot k div N.
- R2: `load_done` is 0 after reset. It goes to 1 in the cycle after the N×E-th accepted word, where E is the number of edges per cam, and it stays 1 until reset. Load words offered after that are ignored.
- R3: While `load_done` is 0, every bit of `cam_out` is 0.
- R4: Let k be the number of active table entries whose value is less than or equal to the cam's effective angle. With `cfg_first_rising`=1 the cam output is 1 when k is odd. With `cfg_first_rising`=0 it is 1 when k is even.
- R5: `cam_out` is registered. It shows the result for the inputs present before the most recent clock edge.
- R6: With `cfg_half_speed`=0, `adj_angle` equals `crank_angle`. With `cfg_half_speed`=1, an internal half bit flips on every clock edge at which `rev_mark` is 1, and reset clears it. Whenever the current half bit XOR `rev_mark` is 1, `adj_angle` is `crank_angle`+`DEG360`; otherwise it is `crank_angle`.
- R7: A cam's effective angle is `adj_angle` minus its offset, taken modulo the cycle length. The cycle length is `DEG360`, or 2×`DEG360` in half-speed mode. Cam i's offset is bits [i×ANG_W +: ANG_W] of `vvt_offsets`. A new offset is used from the next output update.
- R8: The output of a cam whose index is at or above `cfg_num_cams` stays 0.
- R9: Only the first `cfg_edges_per_cam` slots of each table take part in R4. Stale values in the slots above that have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_half_speed | input | 1 | 1 selects a 720 degree cam cycle |
| cfg_first_rising | input | 1 | Polarity of the first table edge (1 = rising) |
| cfg_num_cams | input | 3 | Number of active cams, 1 to 4 |
| cfg_edges_per_cam | input | 7 | Table entries per cam, 1 to 64, even |
| ld_valid | input | 1 | Load word present |
| ld_angle | input | ANG_W | Load word: one edge angle |
| crank_angle | input | ANG_W | Crank angle, 0 to DEG360-1 |
| rev_mark | input | 1 | 1 on the first sample of each crank revolution |
| vvt_offsets | input | MAX_CAMS×ANG_W | Per-cam timing offsets, each below the cycle length |
| adj_angle | output | ANG_W | Crank angle extended to the cam cycle |
| cam_out | output | MAX_CAMS | Cam sensor levels |
| load_done | output | 1 | All table words received |

## Verification
If a word lands in the wrong table slot, the cam that owns that slot flips at the wrong angle. The first sweep through that angle after loading shows this on `cam_out`, and a neighbouring cam shows a matching fault. A stuck or misplaced half bit puts `adj_angle` off by exactly one revolution from the first revolution marker on. That error is visible in the same cycle. A wrong wrap or offset sign moves an edge by the offset amount, which shows up one cycle after the sweep reaches it. A loader that finishes early or late shows up as cam activity during loading, or as a late `load_done`.

// File: rtl/cam_pkg.sv
// Shared definitions for the cam generator: cycle mode and edge-level rule.
package cam_pkg;

    typedef enum logic {
        CYC_ONE_REV = 1'b0,
        CYC_TWO_REV = 1'b1
    } cyc_mode_e;

    // Level of a cam line given the parity of passed edges and first-edge polarity.
    function automatic logic edge_level(input logic passed_odd, input logic first_rising);
        return first_rising ? passed_odd : ~passed_odd;
    endfunction

endpackage

// File: rtl/cam_angle_adj.sv
// Extends the 0..DEG360-1 crank angle to a two-revolution cycle in half-speed
// mode. Assumes rev_mark is high on the first sample of each new revolution.
module cam_angle_adj #(
    parameter int ANG_W  = 14,
    parameter int DEG360 = 3600
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             half_speed,
    input  logic [ANG_W-1:0] crank_angle,
    input  logic             rev_mark,
    output logic [ANG_W-1:0] adj_angle
);
    localparam logic [ANG_W-1:0] REV_CNT = ANG_W'(DEG360);

    logic half_q;
    logic half_now;

    // Half-cycle bit flips on each revolution marker; held clear at full speed.
    always_ff @(posedge clk) begin
        if (!rst_n)           half_q <= 1'b0;
        else if (!half_speed) half_q <= 1'b0;
        else                  half_q <= half_q ^ rev_mark;
    end

    // The marker cycle already belongs to the new half.
    always_comb begin
        half_now  = half_speed & (half_q ^ rev_mark);
        adj_angle = half_now ? crank_angle + REV_CNT : crank_angle;
    end

endmodule

// File: rtl/cam_loader.sv
// Routes stream words to cam tables in round-robin order until
// edges_per_cam * num_cams words are taken. Assumes configuration is stable.
module cam_loader #(
    parameter int MAX_CAMS  = 4,
    parameter int MAX_EDGES = 64,
    localparam int NCAM_W   = $clog2(MAX_CAMS + 1),
    localparam int EDGE_W   = $clog2(MAX_EDGES + 1),
    localparam int CIDX_W   = (MAX_CAMS > 1) ? $clog2(MAX_CAMS) : 1,
    localparam int SLOT_W   = (MAX_EDGES > 1) ? $clog2(MAX_EDGES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NCAM_W-1:0] num_cams,
    input  logic [EDGE_W-1:0] edges_per_cam,
    input  logic              ld_valid,
    output logic              wr_en,
    output logic [CIDX_W-1:0] wr_cam,
    output logic [SLOT_W-1:0] wr_slot,
    output logic              done
);
    localparam int TOT_W = $clog2(MAX_CAMS * MAX_EDGES + 1);

    logic [TOT_W-1:0] taken_q;
    logic [TOT_W-1:0] target;
    logic             last_cam;

    // Total word count and which cam closes a round.
    always_comb begin
        target   = TOT_W'(edges_per_cam) * TOT_W'(num_cams);
        last_cam = ({1'b0, wr_cam} == (NCAM_W + 1)'(num_cams) - (NCAM_W + 1)'(1));
        wr_en    = ld_valid & ~done;
    end

    // Advance cam index, slot and word count on each accepted word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_cam  <= '0;
            wr_slot <= '0;
            taken_q <= '0;
            done    <= 1'b0;
        end else if (wr_en) begin
            taken_q <= taken_q + TOT_W'(1);
            if (taken_q + TOT_W'(1) == target) done <= 1'b1;
            if (last_cam) begin
                wr_cam  <= '0;
                wr_slot <= wr_slot + SLOT_W'(1);
            end else begin
                wr_cam  <= wr_cam + CIDX_W'(1);
            end
        end
    end

endmodule

// File: rtl/cam_channel.sv
// One cam: edge table, offset wrap and level decision. Assumes the offset is
// below the cycle length and the active entries are ascending.
module cam_channel #(
    parameter int ANG_W     = 14,
    parameter int DEG360    = 3600,
    parameter int MAX_EDGES = 64,
    localparam int EDGE_W   = $clog2(MAX_EDGES + 1),
    localparam int SLOT_W   = (MAX_EDGES > 1) ? $clog2(MAX_EDGES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              half_speed,
    input  logic              first_rising,
    input  logic              active,
    input  logic              run,
    input  logic [EDGE_W-1:0] edges_per_cam,
    input  logic              wr_en,
    input  logic [SLOT_W-1:0] wr_slot,
    input  logic [ANG_W-1:0]  wr_angle,
    input  logic [ANG_W-1:0]  adj_angle,
    input  logic [ANG_W-1:0]  vvt,
    output logic              cam_q
);
    import cam_pkg::*;

    logic [ANG_W-1:0] tbl [MAX_EDGES];
    cyc_mode_e        mode;
    logic [ANG_W:0]   cyc_len;
    logic [ANG_W:0]   diff;
    logic [ANG_W:0]   wrapped;
    logic [ANG_W-1:0] eff;
    logic             passed_odd;

    // Table storage; written only while loading, so no reset is needed.
    always_ff @(posedge clk) begin
        if (wr_en) tbl[wr_slot] <= wr_angle;
    end

    // Effective angle: adjusted angle minus offset, folded into the cycle.
    always_comb begin
        mode    = half_speed ? CYC_TWO_REV : CYC_ONE_REV;
        cyc_len = (mode == CYC_TWO_REV) ? (ANG_W + 1)'(2 * DEG360) : (ANG_W + 1)'(DEG360);
        diff    = {1'b0, adj_angle} - {1'b0, vvt};
        wrapped = diff[ANG_W] ? diff + cyc_len : diff;
        eff     = wrapped[ANG_W-1:0];
    end

    // Parity of active entries at or below the effective angle.
    always_comb begin
        passed_odd = 1'b0;
        for (int j = 0; j < MAX_EDGES; j++) begin
            if ((j < int'(edges_per_cam)) && (tbl[j] <= eff)) passed_odd = ~passed_odd;
        end
    end

    // Registered line level; low until loaded and while the cam is unused.
    always_ff @(posedge clk) begin
        if (!rst_n)       cam_q <= 1'b0;
        else if (!active) cam_q <= 1'b0;
        else if (run)     cam_q <= edge_level(passed_odd, first_rising);
    end

endmodule

// File: rtl/cam_gen_top.sv
// Cam generator top: one loader, one angle extender, MAX_CAMS channels.
// Assumes configuration inputs are set during reset and held afterwards.
module cam_gen_top #(
    parameter int ANG_W     = 14,
    parameter int DEG360    = 3600,
    parameter int MAX_CAMS  = 4,
    parameter int MAX_EDGES = 64,
    localparam int NCAM_W   = $clog2(MAX_CAMS + 1),
    localparam int EDGE_W   = $clog2(MAX_EDGES + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cfg_half_speed,
    input  logic                      cfg_first_rising,
    input  logic [NCAM_W-1:0]         cfg_num_cams,
    input  logic [EDGE_W-1:0]         cfg_edges_per_cam,
    input  logic                      ld_valid,
    input  logic [ANG_W-1:0]          ld_angle,
    input  logic [ANG_W-1:0]          crank_angle,
    input  logic                      rev_mark,
    input  logic [MAX_CAMS*ANG_W-1:0] vvt_offsets,
    output logic [ANG_W-1:0]          adj_angle,
    output logic [MAX_CAMS-1:0]       cam_out,
    output logic                      load_done
);
    localparam int CIDX_W = (MAX_CAMS > 1) ? $clog2(MAX_CAMS) : 1;
    localparam int SLOT_W = (MAX_EDGES > 1) ? $clog2(MAX_EDGES) : 1;

    logic              wr_en;
    logic [CIDX_W-1:0] wr_cam;
    logic [SLOT_W-1:0] wr_slot;

    cam_loader #(.MAX_CAMS(MAX_CAMS), .MAX_EDGES(MAX_EDGES)) u_loader (
        .clk(clk), .rst_n(rst_n),
        .num_cams(cfg_num_cams), .edges_per_cam(cfg_edges_per_cam),
        .ld_valid(ld_valid),
        .wr_en(wr_en), .wr_cam(wr_cam), .wr_slot(wr_slot), .done(load_done)
    );

    cam_angle_adj #(.ANG_W(ANG_W), .DEG360(DEG360)) u_adj (
        .clk(clk), .rst_n(rst_n), .half_speed(cfg_half_speed),
        .crank_angle(crank_angle), .rev_mark(rev_mark), .adj_angle(adj_angle)
    );

    for (genvar g = 0; g < MAX_CAMS; g++) begin : g_cam
        logic cam_wr;
        logic cam_act;
        // Per-cam write strobe and enable from the configured cam count.
        always_comb begin
            cam_wr  = wr_en & (wr_cam == CIDX_W'(g));
            cam_act = (NCAM_W'(g) < cfg_num_cams);
        end

        cam_channel #(.ANG_W(ANG_W), .DEG360(DEG360), .MAX_EDGES(MAX_EDGES)) u_chan (
            .clk(clk), .rst_n(rst_n),
            .half_speed(cfg_half_speed), .first_rising(cfg_first_rising),
            .active(cam_act), .run(load_done),
            .edges_per_cam(cfg_edges_per_cam),
            .wr_en(cam_wr), .wr_slot(wr_slot), .wr_angle(ld_angle),
            .adj_angle(adj_angle), .vvt(vvt_offsets[g*ANG_W +: ANG_W]),
            .cam_q(cam_out[g])
        );
    end

endmodule

// File: rtl/cam_gen_checker.sv
// Port-level properties of the cam generator, bound into every instance.
module cam_gen_checker #(
    parameter int ANG_W     = 14,
    parameter int DEG360    = 3600,
    parameter int MAX_CAMS  = 4,
    localparam int NCAM_W   = $clog2(MAX_CAMS + 1)
) (
    input logic                clk,
    input logic                rst_n,
    input logic                cfg_half_speed,
    input logic [NCAM_W-1:0]   cfg_num_cams,
    input logic [ANG_W-1:0]    crank_angle,
    input logic [ANG_W-1:0]    adj_angle,
    input logic [MAX_CAMS-1:0] cam_out,
    input logic                load_done
);
    a_r3_quiet_until_loaded: assert property (@(posedge clk) disable iff (!rst_n)
        !load_done |-> (cam_out == '0));

    a_r2_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        load_done |=> load_done);

    a_r6_full_speed_passthru: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_half_speed |-> (adj_angle == crank_angle));

    a_r6_half_speed_offset: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_half_speed |-> ((adj_angle == crank_angle) ||
                            (adj_angle == crank_angle + ANG_W'(DEG360))));

    for (genvar i = 0; i < MAX_CAMS; i++) begin : g_idle
        a_r8_unused_cam_low: assert property (@(posedge clk) disable iff (!rst_n)
            (NCAM_W'(i) >= cfg_num_cams) |=> !cam_out[i]);
    end

endmodule

bind cam_gen_top cam_gen_checker #(
    .ANG_W(ANG_W), .DEG360(DEG360), .MAX_CAMS(MAX_CAMS)
) u_cam_gen_checker (.*);

// File: tb/cam_gen_top_bench.sv
module cam_gen_top_bench;
    localparam int ANG_W = 14;
    localparam int REV   = 3600;
    localparam int NC    = 4;
    localparam int NE    = 64;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_half_speed = 1'b0;
    logic              cfg_first_rising = 1'b1;
    logic [2:0]        cfg_num_cams = 3'd1;
    logic [6:0]        cfg_edges_per_cam = 7'd2;
    logic              ld_valid = 1'b0;
    logic [ANG_W-1:0]  ld_angle = '0;
    logic [ANG_W-1:0]  crank_angle = '0;
    logic              rev_mark = 1'b0;
    logic [NC*ANG_W-1:0] vvt_offsets = '0;
    logic [ANG_W-1:0]  adj_angle;
    logic [NC-1:0]     cam_out;
    logic              load_done;

    cam_gen_top u_cam_gen_top (.*);

    always #4 clk = ~clk;

    typedef struct { logic [NC-1:0] cams; logic done; } exp_t;
    exp_t exp_q[$];

    int n_checks = 0;
    int n_errors = 0;
    int tb_tbl [NC][NE];
    int vvt [NC];
    int m_cams, m_edges, m_cnt;
    bit m_fr, m_half_cfg, m_half, m_done;
    bit finished = 0;

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, expv, $time);
        end
    endtask

    // Monitor: compare registered outputs one edge after each driven cycle.
    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            check(cam_out === e.cams, "R1 R3 R4 R5 R7 R8 R9 cam_out", int'(cam_out), int'(e.cams));
            check(load_done === e.done, "R2 load_done", int'(load_done), int'(e.done));
        end
    end

    // Driver: apply one cycle of inputs and queue the expected result.
    task automatic drive(input int crank, input bit rev, input bit lv, input int la);
        int   expadj, eff, cyc, k;
        bit   hnow;
        exp_t e;
        @(negedge clk);
        crank_angle = ANG_W'(crank);
        rev_mark    = rev;
        ld_valid    = lv;
        ld_angle    = ANG_W'(la);
        for (int c = 0; c < NC; c++) vvt_offsets[c*ANG_W +: ANG_W] = ANG_W'(vvt[c]);
        hnow   = m_half_cfg && (m_half ^ rev);
        expadj = crank + (hnow ? REV : 0);
        #1;
        check(int'(adj_angle) == expadj, "R6 adj_angle", int'(adj_angle), expadj);
        cyc = m_half_cfg ? 2 * REV : REV;
        e.cams = '0;
        for (int c = 0; c < NC; c++) begin
            if (m_done && c < m_cams) begin
                eff = expadj - vvt[c];
                if (eff < 0) eff += cyc;
                k = 0;
                for (int j = 0; j < m_edges; j++) if (tb_tbl[c][j] <= eff) k++;
                e.cams[c] = m_fr ? (k % 2 == 1) : (k % 2 == 0);
            end
        end
        if (lv && !m_done) begin
            m_cnt++;
            if (m_cnt == m_cams * m_edges) m_done = 1;
        end
        e.done = m_done;
        m_half = m_half_cfg ? (m_half ^ rev) : 1'b0;
        exp_q.push_back(e);
    endtask

    task automatic do_reset(input bit half, input bit fr, input int ncams, input int nedges);
        @(negedge clk);
        rst_n = 1'b0;
        ld_valid = 1'b0;
        cfg_half_speed = half;
        cfg_first_rising = fr;
        cfg_num_cams = 3'(ncams);
        cfg_edges_per_cam = 7'(nedges);
        m_half_cfg = half; m_fr = fr; m_cams = ncams; m_edges = nedges;
        m_half = 0; m_done = 0; m_cnt = 0;
        repeat (3) @(posedge clk);
        #1;
        check(cam_out === '0, "R3 reset cam_out", int'(cam_out), 0);
        check(load_done === 1'b0, "R2 reset load_done", int'(load_done), 0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Stream the tables in interleaved order while the crank turns.
    task automatic load_all();
        for (int s = 0; s < m_edges; s++)
            for (int c = 0; c < m_cams; c++)
                drive((s * 300 + c * 100) % REV, 0, 1, tb_tbl[c][s]);
    endtask

    initial begin
        for (int c = 0; c < NC; c++) vvt[c] = 0;
        // Phase 1: full speed, 3 cams, 4 edges, first edge rising.
        tb_tbl[0][0] = 100;  tb_tbl[0][1] = 200;  tb_tbl[0][2] = 1000; tb_tbl[0][3] = 2000;
        tb_tbl[1][0] = 300;  tb_tbl[1][1] = 400;  tb_tbl[1][2] = 500;  tb_tbl[1][3] = 600;
        tb_tbl[2][0] = 50;   tb_tbl[2][1] = 3000; tb_tbl[2][2] = 3100; tb_tbl[2][3] = 3500;
        do_reset(0, 1, 3, 4);
        load_all();
        drive(0, 1, 1, 7);   // R2: word beyond the total is ignored
        drive(10, 0, 1, 9);
        for (int a = 0; a < REV; a += 50) drive(a, a == 0, 0, 0);      // R4 R8
        vvt[0] = 150; vvt[2] = 3590;                                    // R7 wrap
        for (int a = 0; a < REV; a += 25) drive(a, a == 0, 0, 0);

        // Phase 2: half speed, 4 cams, 2 edges, first edge falling; stale slots remain (R9).
        for (int c = 0; c < NC; c++) vvt[c] = 0;
        tb_tbl[0][0] = 100;  tb_tbl[0][1] = 5000;
        tb_tbl[1][0] = 3700; tb_tbl[1][1] = 3800;
        tb_tbl[2][0] = 10;   tb_tbl[2][1] = 20;
        tb_tbl[3][0] = 3599; tb_tbl[3][1] = 7199;
        do_reset(1, 0, 4, 2);
        load_all();
        for (int r = 0; r < 2; r++)
            for (int a = 0; a < REV; a += 100) drive(a, a == 0, 0, 0);  // R6
        vvt[1] = 7000; vvt[3] = 100;                                    // R7 two-rev wrap
        for (int r = 0; r < 2; r++)
            for (int a = 0; a < REV; a += 50) drive(a, a == 0, 0, 0);
        drive(3599, 0, 0, 0);
        drive(0, 1, 0, 0);
        repeat (3) @(posedge clk);
        #2;
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

endmodule